// File: doc/BRIEF.md
# Rotating slot shared memory

This block connects a set of requesters to one shared word memory. The memory is cut into as many slices as there are requesters, and the low bits of a word address pick the slice. A free-running phase counter turns the slice-to-requester pairing by one position every clock. Each requester therefore faces every slice exactly once per turn of the counter, and no two requesters ever face the same slice. The block needs no arbitration at all. The time an access waits depends only on its address and on the phase at which it is presented, so every access has a fixed, predictable latency.

A requester drives one request and holds it until its slot arrives. At the slot a write lands in the slice array, and a read captures the word. The read then returns through a fixed five-stage return path. A request is consumed at its slot edge, and the requester may present the next one in the very next cycle. Consecutive addresses sit in consecutive slices, so a burst that follows the rotation moves one word per clock once the first word is aligned. The requester is expected to know its own slot timing, because that timing is fully determined.

Top module: `slot_rotor_mem`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase counter clears to 0, `req_done`, `rd_valid` and `rd_data` clear to zero, and every memory word clears to 0. A read after reset returns 0.
- R2: The phase counter is 0 in the first cycle after reset and advances by 1 modulo NR every clock. Requester r is served in a cycle with phase p only if its address bits [LG-1:0] equal (r + p) mod NR. A write presented with offset d = (slice − r − p) mod NR therefore has `req_done` high exactly d+1 cycles later.
- R3: `req_done[r]` is high for exactly the cycle after each edge at which requester r's write was served, and at no other time.
- R4: `rd_valid[r]` is high exactly 5 cycles after the edge at which requester r's read was served. The total read latency is d+5 cycles.
- R5: `rd_data` for a read carries the value of the word as it stood at the read's slot. That value is the last write served before that slot, or 0 after reset.
- R6: All NR requesters can be served in the same cycle, because each one faces a different slice.
- R7: A requester that presents consecutive addresses back to back, each from the cycle after the previous one was served, gets one completion per clock for the whole burst.
- R8: A request presented at the same phase as an earlier one, that is a multiple of NR cycles later, to the same address sees the same latency.
- R9: A write request withdrawn before its slot arrives changes no memory word and produces no `req_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NR | Request present, one bit per requester |
| req_write | input | NR | 1 = write, 0 = read, per requester |
| req_addr | input | NR*AW | Word address per requester; bits [LG-1:0] select the slice |
| req_wdata | input | NR*DW | Write data per requester |
| req_done | output | NR | Write completed at the previous slot edge |
| rd_valid | output | NR | Read data valid on `rd_data` |
| rd_data | output | NR*DW | Read data per requester |

## Verification
The bench goes after the phase arithmetic. It checks that latency matches (slice − r − p) mod NR for single writes and reads, and that reissuing at the same phase repeats the latency. An off-by-one in the phase or in the slice match would shift every latency and break these checks. All sixteen requesters run aligned bursts at once. A design that let two requesters meet the same slice, or that stalled after the first word, would lose words or break the one-per-clock completion run. The bench also withdraws a write before its slot, mixes overlapping reads and writes across requesters, and applies a reset in mid-run. A design that committed early, returned a stale word or kept memory through reset would show a data miscompare.

// File: rtl/slot_rotor_mem.sv
`timescale 1ns/1ps
module slot_rotor_mem #(
  parameter int NR = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NR-1:0]    req_valid,
  input  logic [NR-1:0]    req_write,
  input  logic [NR*AW-1:0] req_addr,
  input  logic [NR*DW-1:0] req_wdata,
  output logic [NR-1:0]    req_done,
  output logic [NR-1:0]    rd_valid,
  output logic [NR*DW-1:0] rd_data
);
  localparam int LG    = $clog2(NR);
  localparam int IW    = AW - LG;
  localparam int DEPTH = 1 << IW;
  localparam int RL    = 5;

  logic [LG-1:0] ph;
  logic [DW-1:0] slice_rd [NR];

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + 1'b1;
  end

  for (genvar s = 0; s < NR; s++) begin : g_slice
    logic [LG-1:0] own;
    logic [AW-1:0] oa;
    logic          wr;
    logic [DW-1:0] cells [DEPTH];

    assign own = LG'(s) - ph;
    assign oa  = req_addr[own*AW +: AW];
    assign wr  = req_valid[own] && req_write[own] && (oa[LG-1:0] == LG'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr) begin
        cells[oa[AW-1:LG]] <= req_wdata[own*DW +: DW];
      end
    end

    assign slice_rd[s] = cells[oa[AW-1:LG]];
  end

  for (genvar r = 0; r < NR; r++) begin : g_req
    logic [LG-1:0] sl;
    logic          hit;
    logic          done_q;
    logic [RL-1:0] pv;
    logic [DW-1:0] pd [RL];

    assign sl  = LG'(r) + ph;
    assign hit = req_valid[r] && (req_addr[r*AW +: LG] == sl);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        pv     <= '0;
        for (int k = 0; k < RL; k++) pd[k] <= '0;
      end else begin
        done_q <= hit && req_write[r];
        pv     <= {pv[RL-2:0], hit && !req_write[r]};
        pd[0]  <= (hit && !req_write[r]) ? slice_rd[sl] : '0;
        for (int k = 1; k < RL; k++) pd[k] <= pd[k-1];
      end
    end

    assign req_done[r]          = done_q;
    assign rd_valid[r]          = pv[RL-1];
    assign rd_data[r*DW +: DW]  = pd[RL-1];
  end
endmodule

// File: rtl/slot_rotor_mem_chk.sv
`timescale 1ns/1ps
module slot_rotor_mem_chk #(
  parameter int NR = 16,
  parameter int LG = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NR-1:0] req_valid,
  input logic [NR-1:0] req_write,
  input logic [NR-1:0] req_done,
  input logic [NR-1:0] rd_valid,
  input logic [LG-1:0] ph
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (req_done == '0 && rd_valid == '0 && ph == '0));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ph == LG'($past(ph) + 1'b1));

  p_done_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_done & ~$past(req_valid & req_write)) == '0);

  p_read_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid & ~$past(req_valid & ~req_write, 5)) == '0);
endmodule

bind slot_rotor_mem slot_rotor_mem_chk #(.NR(NR), .LG(LG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_done(req_done), .rd_valid(rd_valid), .ph(ph)
);

// File: tb/slot_rotor_mem_tb_top.sv
`timescale 1ns/1ps
module slot_rotor_mem_tb_top;
  localparam int NR = 16, AW = 8, DW = 32, LG = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [NR-1:0]    req_valid = '0, req_write = '0;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR*DW-1:0] req_wdata = '0;
  logic [NR-1:0]    req_done, rd_valid;
  logic [NR*DW-1:0] rd_data;

  slot_rotor_mem #(.NR(NR), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // reference model state
  int            cyc = 0, mph = 0, nvec = 0, nbad = 0;
  bit            rst_req = 1'b0;
  logic [DW-1:0] mm [1<<AW];
  logic [NR-1:0] pv [5];
  logic [DW-1:0] pd [5][NR];
  logic [NR-1:0] exp_done = '0;
  // per-requester op queues: kind 0 write, 1 read, 2 withdrawn write, 3 wait for same phase, 4 idle
  int            qk [NR][$];
  int            qa [NR][$];
  logic [DW-1:0] qd [NR][$];
  bit            fresh [NR];
  int            issue_cyc [NR], issue_ph [NR], lat_last [NR], run [NR], best_run [NR];
  logic [DW-1:0] cap [NR];
  int            max_pop = 0, abort_addr = 0;

  function automatic logic [DW-1:0] wval(int r, int a, int salt);
    return 32'(a * 40503) ^ (32'(r) << 24) ^ 32'(salt);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  task automatic pop(int r);
    void'(qk[r].pop_front()); void'(qa[r].pop_front()); void'(qd[r].pop_front());
    fresh[r] = 1'b1;
  endtask

  task automatic push(int r, int k, int a, logic [DW-1:0] d);
    qk[r].push_back(k); qa[r].push_back(a); qd[r].push_back(d);
  endtask

  task automatic drive_one(int r);
    req_valid[r] = 1'b0;
    req_write[r] = 1'b0;
    while (qk[r].size() > 0 && qk[r][0] == 3 && cyc > issue_cyc[r] &&
           ((cyc - issue_cyc[r]) % NR) == 0) pop(r);
    if (qk[r].size() > 0) begin
      case (qk[r][0])
        0, 1: begin
          req_valid[r] = 1'b1;
          req_write[r] = (qk[r][0] == 0);
          req_addr[r*AW +: AW]  = AW'(qa[r][0]);
          req_wdata[r*DW +: DW] = qd[r][0];
          if (fresh[r]) begin issue_cyc[r] = cyc; issue_ph[r] = mph; fresh[r] = 1'b0; end
        end
        2: begin
          abort_addr = (qa[r][0] & ~(NR-1)) | ((r + mph + NR/2) % NR);
          req_valid[r] = 1'b1;
          req_write[r] = 1'b1;
          req_addr[r*AW +: AW]  = AW'(abort_addr);
          req_wdata[r*DW +: DW] = qd[r][0];
        end
        4: pop(r);
        default: ;
      endcase
    end
  endtask

  task automatic eval();
    logic [NR-1:0] nd, nv;
    logic [DW-1:0] ndat [NR];
    nd = '0; nv = '0;
    if (!rst_n) begin
      mph = 0; exp_done = '0;
      for (int k = 0; k < 5; k++) begin
        pv[k] = '0;
        for (int r = 0; r < NR; r++) pd[k][r] = '0;
      end
      for (int a = 0; a < (1<<AW); a++) mm[a] = '0;
      return;
    end
    for (int r = 0; r < NR; r++) begin
      ndat[r] = '0;
      if (req_valid[r] && req_addr[r*AW +: LG] == LG'((r + mph) % NR)) begin
        if (req_write[r]) begin
          nd[r] = 1'b1;
          mm[req_addr[r*AW +: AW]] = req_wdata[r*DW +: DW];
        end else begin
          nv[r] = 1'b1;
          ndat[r] = mm[req_addr[r*AW +: AW]];
        end
        if (qk[r].size() > 0 && qk[r][0] <= 1) pop(r);
      end
      if (qk[r].size() > 0 && qk[r][0] == 2) pop(r);
    end
    for (int k = 4; k > 0; k--) begin
      pv[k] = pv[k-1];
      for (int r = 0; r < NR; r++) pd[k][r] = pd[k-1][r];
    end
    pv[0] = nv;
    for (int r = 0; r < NR; r++) pd[0][r] = ndat[r];
    exp_done = nd;
    mph = (mph + 1) % NR;
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog expired", 64'(cyc), 64'd150000);
      finish_up();
    end
    chk(req_done === exp_done, "R3 write completion", 64'(req_done), 64'(exp_done));
    chk(rd_valid === pv[4], "R4 read return timing", 64'(rd_valid), 64'(pv[4]));
    for (int r = 0; r < NR; r++) begin
      if (pv[4][r])
        chk(rd_data[r*DW +: DW] === pd[4][r], "R5 read data", 64'(rd_data[r*DW +: DW]), 64'(pd[4][r]));
      if (req_done[r] || rd_valid[r]) lat_last[r] = cyc - issue_cyc[r];
      if (rd_valid[r]) cap[r] = rd_data[r*DW +: DW];
      run[r] = req_done[r] ? run[r] + 1 : 0;
      if (run[r] > best_run[r]) best_run[r] = run[r];
    end
    if ($countones(req_done) > max_pop) max_pop = $countones(req_done);
    rst_n = rst_req;
    for (int r = 0; r < NR; r++) drive_one(r);
    eval();
  endtask

  function automatic bit busy();
    for (int r = 0; r < NR; r++) if (qk[r].size() > 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drain();
    while (busy()) tick();
    repeat (8) tick();
  endtask

  task automatic clear_stats();
    max_pop = 0;
    for (int r = 0; r < NR; r++) begin run[r] = 0; best_run[r] = 0; end
  endtask

  initial begin
    int l1, l2;
    for (int r = 0; r < NR; r++) begin
      fresh[r] = 1'b1; issue_cyc[r] = 0; issue_ph[r] = 0; lat_last[r] = 0; cap[r] = '1;
    end
    for (int a = 0; a < (1<<AW); a++) mm[a] = '0;
    for (int k = 0; k < 5; k++) begin
      pv[k] = '0;
      for (int r = 0; r < NR; r++) pd[k][r] = '0;
    end
    repeat (4) tick();
    // R1: quiet outputs while reset is held
    chk(req_done == '0 && rd_valid == '0 && rd_data == '0, "R1 reset outputs",
        64'(req_done | rd_valid), 64'd0);
    rst_req = 1'b1;
    tick();

    // R2 / R4: single write and read latency by slot offset; R1: untouched word reads 0
    push(3, 0, 'h25, wval(3, 'h25, 1));
    drain();
    chk(lat_last[3] == ((5 - 3 - issue_ph[3]) & 15) + 1, "R2 write latency",
        64'(lat_last[3]), 64'(((5 - 3 - issue_ph[3]) & 15) + 1));
    push(3, 1, 'h25, '0);
    drain();
    chk(lat_last[3] == ((5 - 3 - issue_ph[3]) & 15) + 5, "R4 read latency",
        64'(lat_last[3]), 64'(((5 - 3 - issue_ph[3]) & 15) + 5));
    chk(cap[3] == wval(3, 'h25, 1), "R5 read-back", 64'(cap[3]), 64'(wval(3, 'h25, 1)));
    push(1, 1, 'h37, '0);
    drain();
    chk(cap[1] == '0, "R1 memory cleared", 64'(cap[1]), 64'd0);

    // R8: same phase, same address, same latency
    push(7, 1, 'h4C, '0);
    drain();
    l1 = lat_last[7];
    push(7, 3, 0, '0);
    push(7, 1, 'h4C, '0);
    drain();
    l2 = lat_last[7];
    chk(l1 == l2, "R8 repeat latency", 64'(l2), 64'(l1));

    // R6 / R7: every requester bursts 16 consecutive words at once
    clear_stats();
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < NR; i++) push(r, 0, r*NR + i, wval(r, r*NR + i, 7));
    drain();
    chk(max_pop == NR, "R6 all requesters served together", 64'(max_pop), 64'(NR));
    chk(best_run[0] == NR, "R7 burst one per clock (req 0)", 64'(best_run[0]), 64'(NR));
    chk(best_run[15] == NR, "R7 burst one per clock (req 15)", 64'(best_run[15]), 64'(NR));
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < NR; i++) push(r, 1, ((r + 5) % NR)*NR + i, '0);
    drain();

    // R9: withdrawn write leaves memory alone
    clear_stats();
    push(5, 2, 'h50, 32'hDEAD_BEEF);
    drain();
    chk(best_run[5] == 0, "R9 no completion for withdrawn write", 64'(best_run[5]), 64'd0);
    push(5, 1, abort_addr, '0);
    drain();
    chk(cap[5] == wval(5, abort_addr, 7), "R9 word unchanged", 64'(cap[5]),
        64'(wval(5, abort_addr, 7)));

    // mixed overlapping traffic with idles
    for (int n = 0; n < 120; n++)
      for (int r = 0; r < NR; r++) begin
        int k;
        k = ((n*7 + r) % 5 == 0) ? 4 : (((n*3 + r) % 3 == 0) ? 1 : 0);
        push(r, k, (n*37 + r*11) & 255, wval(r, n, 99));
      end
    drain();

    // R1: reset in mid-run clears memory
    rst_req = 1'b0;
    repeat (3) tick();
    chk(req_done == '0 && rd_valid == '0, "R1 mid-run reset outputs",
        64'(req_done | rd_valid), 64'd0);
    rst_req = 1'b1;
    tick();
    push(2, 1, 'h2A, '0);
    drain();
    chk(cap[2] == '0, "R1 memory cleared after reset", 64'(cap[2]), 64'd0);

    finish_up();
  end
endmodule